// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block keeps a small direct-mapped write-back data cache coherent with its peers on a shared snooping bus. Every line carries one of three states: Invalid, Shared (clean, may be held by other caches) or Modified (the only copy, and dirty). Requests arrive from two sides. The processor presents loads and stores and waits for a one-cycle ready pulse. The bus presents the commands that other caches issue, and this block watches all of them.

Processor accesses that hit with enough permission finish locally. Any other access becomes a bus command, raised through a request/grant handshake: Read Miss, Write Miss, Invalidate, or Write Back of a dirty victim. Fill data comes back on a separate return input. When a snooped command hits a line, the block updates that line's state. If the line is the dirty copy, the block also drives its data onto the bus so the requester gets it cache to cache.

An address splits into an index (the low `IDX_W` bits) and a tag (the remaining bits). Each line holds one data word of `DATA_W` bits. The bus command encoding is the same on the issue side and the snoop side: 0 = Read Miss, 1 = Write Miss, 2 = Invalidate, 3 = Write Back.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, bus_req, cpu_ready and snp_supply are low. Reset leaves every line Invalid, so the first access to any address misses.
- R2: The following complete with no bus command: a load that hits a Shared or Modified line, and a store that hits a Modified line. cpu_ready rises in the cycle after the request is sampled, and cpu_rdata holds the line's data after the access.
- R3: A store that hits a Shared line raises Invalidate (2) for its address. The store completes only after that command is granted. The line then becomes Modified and holds the new data.
- R4: A load miss raises Read Miss (0), waits for fill data, installs the line as Shared and returns the fill data. A store miss raises Write Miss (1) and installs the line as Modified holding the store data.
- R5: When a miss must replace a Modified line, the block first raises Write Back (3) with the victim's address and data. It raises the miss command only after the Write Back has been granted.
- R6: A snooped Read Miss that hits a Modified line makes the block supply the line's data on snp_data with snp_supply high for one cycle, and the line drops to Shared. A snooped Read Miss that hits a Shared line changes nothing.
- R7: A snooped Invalidate or Write Miss that hits a Shared line makes it Invalid. A snooped Write Miss that hits a Modified line first supplies its data, then the line becomes Invalid. Snooped commands whose tag does not match, or that index an Invalid line, have no effect.
- R8: When a snooped command and an idle processor request arrive in the same cycle, the snoop is handled first. The processor request completes one cycle later than it would have alone.
- R9: Once bus_req is raised, it stays high with bus_cmd and bus_addr unchanged until bus_gnt is seen. The one exception is a withdrawal caused by a snoop (R10).
- R10: If a snoop takes away the line an Invalidate or Write Back is waiting on before grant, the block drops the request and re-evaluates the access. A store whose Shared line was invalidated therefore issues Write Miss.
- R11: cpu_ready is a single-cycle pulse, one per request. It is never high while bus_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present; held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Request address (tag above index) |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Line data after the access |
| bus_req | output | 1 | Bus command request |
| bus_cmd | output | 2 | Command: 0 Read Miss, 1 Write Miss, 2 Invalidate, 3 Write Back |
| bus_addr | output | ADDR_W | Command address |
| bus_wdata | output | DATA_W | Victim data for Write Back |
| bus_gnt | input | 1 | Grant; the command is on the bus this cycle |
| fill_valid | input | 1 | Fill data for the outstanding miss |
| fill_data | input | DATA_W | Fill data word |
| snp_valid | input | 1 | Snooped command present |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_supply | output | 1 | Block is supplying data for the last snoop |
| snp_data | output | DATA_W | Supplied data |

## Verification
The bench builds the controller with an 8-bit address, an 8-bit data word and only four lines (IDX_W = 2). With so few lines, two addresses that share an index come up after a handful of accesses, so eviction of a dirty victim and snoops with a mismatched tag are cheap to reach. The bench's bus responder has a grant delay that can be set per test. With a long delay, a snoop can take a line away while an Invalidate is still waiting, which exercises the withdrawal path. One test drives a snoop and a processor load in the same cycle to observe the ordering.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    BC_RDMISS = 2'd0,
    BC_WRMISS = 2'd1,
    BC_INVAL  = 2'd2,
    BC_WRBACK = 2'd3
  } bus_cmd_t;

  typedef enum logic [2:0] {
    F_IDLE,
    F_WB,
    F_MISS,
    F_WAIT,
    F_INV,
    F_DONE
  } ctl_fsm_t;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_t          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_t          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              wr_en,
  input  logic              wr_fill,
  input  logic [IDX_W-1:0]  wr_idx,
  input  line_st_t          wr_st,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sn_en,
  input  logic [IDX_W-1:0]  sn_idx,
  input  line_st_t          sn_st
);
  localparam int LINES = 1 << IDX_W;

  line_st_t          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  // State bits need reset; a snoop update wins over a processor-side write.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LN_INV;
    end else begin
      if (wr_en) st_q[wr_idx] <= wr_st;
      if (sn_en) st_q[sn_idx] <= sn_st;
    end
  end

  // Tag and data carry no reset so they can map onto RAM.
  always_ff @(posedge clk) begin
    if (wr_en && wr_fill) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_data = data_q[b_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int TAG_W = 2
) (
  input  logic             snp_valid,
  input  logic [1:0]       snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  line_st_t         line_st,
  input  logic [TAG_W-1:0] line_tag,
  output logic             upd_en,
  output line_st_t         upd_st,
  output logic             supply
);
  logic hit;
  assign hit = snp_valid && (line_st != LN_INV) && (line_tag == snp_tag);

  always_comb begin
    upd_en = 1'b0;
    upd_st = line_st;
    supply = 1'b0;
    if (hit) begin
      case (bus_cmd_t'(snp_cmd))
        BC_RDMISS: if (line_st == LN_MOD) begin
          supply = 1'b1;
          upd_en = 1'b1;
          upd_st = LN_SHR;
        end
        BC_WRMISS: begin
          supply = (line_st == LN_MOD);
          upd_en = 1'b1;
          upd_st = LN_INV;
        end
        BC_INVAL: if (line_st == LN_SHR) begin
          upd_en = 1'b1;
          upd_st = LN_INV;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  ctl_fsm_t          fsm_q, fsm_d;
  logic              req_q, req_d;
  bus_cmd_t          cmd_q, cmd_d;
  logic [ADDR_W-1:0] baddr_q, baddr_d;
  logic [DATA_W-1:0] bdata_q, bdata_d;
  logic              rdy_q, rdy_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              sup_q;
  logic [DATA_W-1:0] sdata_q;

  logic              latch;
  logic [ADDR_W-1:0] pend_addr;
  logic              pend_we;
  logic [DATA_W-1:0] pend_wdata;

  logic [ADDR_W-1:0] look_addr;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  line_st_t          a_st, b_st;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;
  logic              hit;

  logic              wr_en, wr_fill;
  line_st_t          wr_st;
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data;
  logic              sn_en, sn_supply;
  line_st_t          sn_st;

  assign look_addr = (fsm_q == F_IDLE) ? cpu_addr : pend_addr;
  assign cur_idx   = look_addr[IDX_W-1:0];
  assign cur_tag   = look_addr[ADDR_W-1:IDX_W];
  assign hit       = (a_st != LN_INV) && (a_tag == cur_tag);

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .a_idx   (cur_idx),
    .a_st    (a_st),
    .a_tag   (a_tag),
    .a_data  (a_data),
    .b_idx   (snp_addr[IDX_W-1:0]),
    .b_st    (b_st),
    .b_tag   (b_tag),
    .b_data  (b_data),
    .wr_en   (wr_en),
    .wr_fill (wr_fill),
    .wr_idx  (cur_idx),
    .wr_st   (wr_st),
    .wr_tag  (wr_tag),
    .wr_data (wr_data),
    .sn_en   (sn_en),
    .sn_idx  (snp_addr[IDX_W-1:0]),
    .sn_st   (sn_st)
  );

  msi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd),
    .snp_tag   (snp_addr[ADDR_W-1:IDX_W]),
    .line_st   (b_st),
    .line_tag  (b_tag),
    .upd_en    (sn_en),
    .upd_st    (sn_st),
    .supply    (sn_supply)
  );

  always_comb begin
    fsm_d   = fsm_q;
    req_d   = req_q;
    cmd_d   = cmd_q;
    baddr_d = baddr_q;
    bdata_d = bdata_q;
    rdy_d   = 1'b0;
    rdata_d = rdata_q;
    latch   = 1'b0;
    wr_en   = 1'b0;
    wr_fill = 1'b0;
    wr_st   = LN_INV;
    wr_tag  = cur_tag;
    wr_data = pend_wdata;
    case (fsm_q)
      F_IDLE: if (cpu_valid && !snp_valid) begin
        latch = 1'b1;
        if (hit && (!cpu_we || a_st == LN_MOD)) begin
          rdy_d = 1'b1;
          fsm_d = F_DONE;
          if (cpu_we) begin
            wr_en   = 1'b1;
            wr_fill = 1'b1;
            wr_st   = LN_MOD;
            wr_data = cpu_wdata;
            rdata_d = cpu_wdata;
          end else begin
            rdata_d = a_data;
          end
        end else if (hit) begin
          req_d   = 1'b1;
          cmd_d   = BC_INVAL;
          baddr_d = cpu_addr;
          fsm_d   = F_INV;
        end else if (a_st == LN_MOD) begin
          req_d   = 1'b1;
          cmd_d   = BC_WRBACK;
          baddr_d = {a_tag, cur_idx};
          bdata_d = a_data;
          fsm_d   = F_WB;
        end else begin
          req_d   = 1'b1;
          cmd_d   = cpu_we ? BC_WRMISS : BC_RDMISS;
          baddr_d = cpu_addr;
          fsm_d   = F_MISS;
          wr_en   = 1'b1;
          wr_st   = LN_INV;
        end
      end
      F_WB: begin
        if (a_st != LN_MOD) begin
          req_d = 1'b0;
          fsm_d = F_IDLE;
        end else if (bus_gnt) begin
          wr_en   = 1'b1;
          wr_st   = LN_INV;
          cmd_d   = pend_we ? BC_WRMISS : BC_RDMISS;
          baddr_d = pend_addr;
          fsm_d   = F_MISS;
        end
      end
      F_MISS: if (bus_gnt) begin
        req_d = 1'b0;
        fsm_d = F_WAIT;
      end
      F_WAIT: if (fill_valid) begin
        wr_en   = 1'b1;
        wr_fill = 1'b1;
        wr_st   = pend_we ? LN_MOD : LN_SHR;
        wr_data = pend_we ? pend_wdata : fill_data;
        rdata_d = pend_we ? pend_wdata : fill_data;
        rdy_d   = 1'b1;
        fsm_d   = F_DONE;
      end
      F_INV: begin
        if (!(a_st == LN_SHR && a_tag == cur_tag)) begin
          req_d = 1'b0;
          fsm_d = F_IDLE;
        end else if (bus_gnt) begin
          req_d   = 1'b0;
          wr_en   = 1'b1;
          wr_fill = 1'b1;
          wr_st   = LN_MOD;
          rdata_d = pend_wdata;
          rdy_d   = 1'b1;
          fsm_d   = F_DONE;
        end
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q   <= F_IDLE;
      req_q   <= 1'b0;
      cmd_q   <= BC_RDMISS;
      baddr_q <= '0;
      bdata_q <= '0;
      rdy_q   <= 1'b0;
      rdata_q <= '0;
      sup_q   <= 1'b0;
      sdata_q <= '0;
    end else begin
      fsm_q   <= fsm_d;
      req_q   <= req_d;
      cmd_q   <= cmd_d;
      baddr_q <= baddr_d;
      bdata_q <= bdata_d;
      rdy_q   <= rdy_d;
      rdata_q <= rdata_d;
      sup_q   <= sn_supply;
      sdata_q <= b_data;
    end
  end

  always_ff @(posedge clk) begin
    if (latch) begin
      pend_addr  <= cpu_addr;
      pend_we    <= cpu_we;
      pend_wdata <= cpu_wdata;
    end
  end

  assign cpu_ready  = rdy_q;
  assign cpu_rdata  = rdata_q;
  assign bus_req    = req_q;
  assign bus_cmd    = cmd_q;
  assign bus_addr   = baddr_q;
  assign bus_wdata  = bdata_q;
  assign snp_supply = sup_q;
  assign snp_data   = sdata_q;
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ready,
  input logic              bus_req,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_gnt,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic              snp_supply
);
  logic snp_d;
  always_ff @(posedge clk) begin
    if (rst) snp_d <= 1'b0;
    else     snp_d <= snp_valid;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!bus_req && !cpu_ready && !snp_supply));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt && !snp_valid && !snp_d)
      |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

  // R11
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R11
  ready_bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !bus_req);

  // R6
  supply_cause_chk: assert property (@(posedge clk) disable iff (rst)
    snp_supply |-> $past(snp_valid));

  // R7
  inval_nosupply_chk: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_cmd == 2'd2) |=> !snp_supply);
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_ready  (cpu_ready),
  .bus_req    (bus_req),
  .bus_cmd    (bus_cmd),
  .bus_addr   (bus_addr),
  .bus_gnt    (bus_gnt),
  .snp_valid  (snp_valid),
  .snp_cmd    (snp_cmd),
  .snp_supply (snp_supply)
);

// File: tb/sim_msi_snoop_ctrl.sv
module sim_msi_snoop_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          cpu_valid, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_gnt;
  logic          fill_valid;
  logic [DW-1:0] fill_data;
  logic          snp_valid;
  logic [1:0]    snp_cmd;
  logic [AW-1:0] snp_addr;
  logic          snp_supply;
  logic [DW-1:0] snp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(2), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
    .fill_valid(fill_valid), .fill_data(fill_data),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_supply(snp_supply), .snp_data(snp_data)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [DW-1:0] mem [256];
  int gnt_delay = 1;
  int wait_cnt = 0;
  int fill_cnt = 0;
  logic [AW-1:0] fill_addr;
  logic [AW-1:0] snp_last;

  // scoreboard queues
  logic [1:0]    eb_cmd [$];
  logic [AW-1:0] eb_addr [$];
  logic [DW-1:0] eb_data [$];
  string         eb_req [$];
  logic [DW-1:0] ec_data [$];
  string         ec_req [$];
  logic [DW-1:0] es_data [$];
  string         es_req [$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic exp_bus(input logic [1:0] c, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input string req);
    eb_cmd.push_back(c); eb_addr.push_back(a); eb_data.push_back(d);
    eb_req.push_back(req);
  endtask

  // Driver: pushes the expected completion and runs one processor access.
  task automatic cpu_op(input bit we, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input logic [DW-1:0] exp,
                        input int exp_lat, input string req);
    int lat;
    ec_data.push_back(exp); ec_req.push_back(req);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!cpu_ready);
    cpu_valid = 1'b0;
    if (exp_lat > 0) check(lat == exp_lat, req, "completion latency", lat, exp_lat);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a,
                       input bit sup, input logic [DW-1:0] d, input string req);
    if (sup) begin es_data.push_back(d); es_req.push_back(req); end
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a; snp_last = a;
    @(negedge clk);
    snp_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Bus responder and monitor
  initial begin
    bus_gnt = 1'b0; fill_valid = 1'b0; fill_data = '0;
    forever begin
      @(negedge clk);
      fill_valid = 1'b0;
      if (fill_cnt > 0) begin
        fill_cnt--;
        if (fill_cnt == 0) begin fill_valid = 1'b1; fill_data = mem[fill_addr]; end
      end
      if (bus_gnt) begin
        bus_gnt = 1'b0; wait_cnt = 0;
      end else if (bus_req) begin
        wait_cnt++;
        if (wait_cnt >= gnt_delay) begin
          bus_gnt = 1'b1;
          if (eb_cmd.size() == 0) begin
            check(1'b0, "R2", "unexpected bus command", int'(bus_cmd), 0);
          end else begin
            logic [1:0] c; logic [AW-1:0] a; logic [DW-1:0] d; string r;
            c = eb_cmd.pop_front(); a = eb_addr.pop_front();
            d = eb_data.pop_front(); r = eb_req.pop_front();
            check(bus_cmd == c, r, "bus command", int'(bus_cmd), int'(c));
            check(bus_addr == a, r, "bus address", int'(bus_addr), int'(a));
            if (c == 2'd3) check(bus_wdata == d, r, "write-back data", int'(bus_wdata), int'(d));
          end
          if (bus_cmd == 2'd3) mem[bus_addr] = bus_wdata;
          else if (bus_cmd != 2'd2) begin fill_addr = bus_addr; fill_cnt = 2; end
        end
      end else begin
        wait_cnt = 0;
      end
      if (snp_supply) begin
        if (es_data.size() == 0) begin
          check(1'b0, "R6", "unexpected supply", int'(snp_data), 0);
        end else begin
          logic [DW-1:0] d; string r;
          d = es_data.pop_front(); r = es_req.pop_front();
          check(snp_data == d, r, "supplied data", int'(snp_data), int'(d));
        end
        mem[snp_last] = snp_data;
      end
      if (cpu_ready) begin
        if (ec_data.size() == 0) begin
          check(1'b0, "R11", "unexpected ready", 1, 0);
        end else begin
          logic [DW-1:0] d; string r;
          d = ec_data.pop_front(); r = ec_req.pop_front();
          check(cpu_rdata == d, r, "cpu data", int'(cpu_rdata), int'(d));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    rst = 1'b1; cpu_valid = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    snp_valid = 1'b0; snp_cmd = '0; snp_addr = '0; snp_last = '0;
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    check(!bus_req && !cpu_ready && !snp_supply, "R1", "idle in reset",
          {bus_req, cpu_ready, snp_supply}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!bus_req && !cpu_ready && !snp_supply, "R1", "idle after reset",
          {bus_req, cpu_ready, snp_supply}, 0);

    // R4 read miss from Invalid (R1: lines start Invalid)
    exp_bus(2'd0, 8'h04, 8'h00, "R4");
    cpu_op(1'b0, 8'h04, 8'h00, 8'h5E, 0, "R4");
    // R2 read hit in Shared
    cpu_op(1'b0, 8'h04, 8'h00, 8'h5E, 1, "R2");
    // R3 write hit in Shared
    exp_bus(2'd2, 8'h04, 8'h00, "R3");
    cpu_op(1'b1, 8'h04, 8'h11, 8'h11, 0, "R3");
    // R2 read and write hits in Modified
    cpu_op(1'b0, 8'h04, 8'h00, 8'h11, 1, "R2");
    cpu_op(1'b1, 8'h04, 8'h22, 8'h22, 1, "R2");
    // R5 read miss replaces Modified victim
    exp_bus(2'd3, 8'h04, 8'h22, "R5");
    exp_bus(2'd0, 8'h14, 8'h00, "R5");
    cpu_op(1'b0, 8'h14, 8'h00, 8'h4E, 0, "R5");
    // R4 write miss
    exp_bus(2'd1, 8'h05, 8'h00, "R4");
    cpu_op(1'b1, 8'h05, 8'h33, 8'h33, 0, "R4");
    // R6 snooped Read Miss on Modified: supply, drop to Shared
    snoop(2'd0, 8'h05, 1'b1, 8'h33, "R6");
    exp_bus(2'd2, 8'h05, 8'h00, "R6");
    cpu_op(1'b1, 8'h05, 8'h44, 8'h44, 0, "R6");
    // R7 snooped Write Miss on Modified: supply, invalidate
    snoop(2'd1, 8'h05, 1'b1, 8'h44, "R7");
    exp_bus(2'd0, 8'h05, 8'h00, "R7");
    cpu_op(1'b0, 8'h05, 8'h00, 8'h44, 0, "R7");
    // R6 snooped Read Miss on Shared: no action; R7 mismatched tag: no action
    snoop(2'd0, 8'h14, 1'b0, 8'h00, "R6");
    snoop(2'd1, 8'h24, 1'b0, 8'h00, "R7");
    cpu_op(1'b0, 8'h14, 8'h00, 8'h4E, 1, "R7");
    // R7 snooped Invalidate on Shared
    snoop(2'd2, 8'h14, 1'b0, 8'h00, "R7");
    exp_bus(2'd0, 8'h14, 8'h00, "R7");
    cpu_op(1'b0, 8'h14, 8'h00, 8'h4E, 0, "R7");

    // R10: Invalidate waiting on a slow grant loses its line to a snoop
    gnt_delay = 4;
    exp_bus(2'd1, 8'h14, 8'h00, "R10");
    ec_data.push_back(8'h66); ec_req.push_back("R10");
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h14; cpu_wdata = 8'h66;
    do @(negedge clk); while (!bus_req);
    snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = 8'h14; snp_last = 8'h14;
    @(negedge clk);
    snp_valid = 1'b0;
    do @(negedge clk); while (!cpu_ready);
    cpu_valid = 1'b0;
    gnt_delay = 1;
    snoop(2'd0, 8'h14, 1'b1, 8'h66, "R10");

    // R8: snoop and processor request in the same cycle
    exp_bus(2'd1, 8'h06, 8'h00, "R8");
    cpu_op(1'b1, 8'h06, 8'h55, 8'h55, 0, "R8");
    es_data.push_back(8'h55); es_req.push_back("R8");
    ec_data.push_back(8'h55); ec_req.push_back("R8");
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h06;
    snp_valid = 1'b1; snp_cmd = 2'd0; snp_addr = 8'h06; snp_last = 8'h06;
    @(negedge clk);
    snp_valid = 1'b0;
    check(!cpu_ready, "R8", "ready deferred by snoop", cpu_ready, 0);
    check(snp_supply, "R8", "snoop handled first", snp_supply, 1);
    @(negedge clk);
    check(cpu_ready, "R8", "ready one cycle later", cpu_ready, 1);
    cpu_valid = 1'b0;
    repeat (4) @(negedge clk);

    // R11: no leftover or missing completions and bus commands
    check(ec_data.size() == 0, "R11", "pending completions", ec_data.size(), 0);
    check(eb_cmd.size() == 0, "R9", "pending bus commands", eb_cmd.size(), 0);
    check(es_data.size() == 0, "R6", "pending supplies", es_data.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule